// File: doc/BRIEF.md
# Dual-Processor Call Dispatcher with Shared-Resource Exclusion and Failover

This block sits between the call intake and two control processors that both run at the same time and split the traffic between them. Each new call request carries an identifier. The block picks a processor for it, either by strict alternation or by a pseudo-random choice, and returns the decision one cycle later. It records the call in a small ownership table, where the call stays bound to that processor until a completion for the same identifier arrives. A combinational lookup port reports whether an identifier is live and which processor owns it.

Each shared resource has an exclusion flag. Either processor may claim a free resource. Once a processor holds it, the other processor is locked out until the holder releases it. A release attempted by the processor that does not hold the flag changes nothing and pulses an error line.

Each processor drives a heartbeat line. A per-processor watchdog declares the processor dead when no heartbeat has been seen for a programmable number of cycles. From then on the survivor receives every new call. It also takes over every live call and every exclusion flag that the dead processor held.

Top module: `callshare_top`

State machines:
- Heartbeat monitor, one per processor, with states HB_WATCH and HB_FAILED. The only transition is the one-way step HB_WATCH to HB_FAILED on timeout.
- Lock controller, one per resource, with states LK_FREE, LK_HELD0 and LK_HELD1. Its transitions are:
  - claim: LK_FREE to LK_HELD0 or LK_HELD1.
  - release: LK_HELDx to LK_FREE.
  - takeover: LK_HELD0 to LK_HELD1 and back, when the holder dies.

## Requirements
- R1: After reset, both `alive` bits are 1, no resource is held, `asg_valid` and `lk_err` are 0, and no identifier is live on the lookup port.
- R2: When `mode_rand`=0 and both processors are alive, accepted requests go to processor 0, 1, 0, 1 … starting with 0. A rejected request does not advance the alternation. `asg_valid`, `asg_busy` and `asg_proc` answer a request on the cycle after it is presented.
- R3: When `mode_rand`=1 and both processors are alive, an accepted request goes to the processor given by bit 0 of a 16-bit register. That register starts at 0xACE1. After each such accepted request it is replaced by {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R4: An accepted call stays owned by the same processor until a completion with its identifier arrives. The call is then no longer live on the lookup port.
- R5: With `N_CALLS` calls live, or with both processors dead, a request is answered with `asg_busy`=1. A completion in the same cycle as the request does not free room for that request.
- R6: A claim on a free resource by a live processor grants it on the next cycle. A claim by the other processor while the resource is held is ignored. This holds even in the cycle in which the holder releases it. A release by the holder frees the resource on the next cycle.
- R7: When both live processors claim the same free resource in one cycle, processor 0 gets it.
- R8: A release by a processor that does not hold that resource changes no flag. It sets that processor's bit of `lk_err` (bit 0 for processor 0, bit 1 for processor 1) for exactly one cycle after the release.
- R9: Suppose a processor's heartbeat is low for `hb_timeout` consecutive cycles, with `hb_timeout` nonzero. Then its `alive` bit falls right after the last of those cycles and never rises again before reset. A `hb_timeout` of 0 disables detection.
- R10: Once one processor is dead, every accepted request goes to the survivor. One cycle after `alive` falls, every live call of the dead processor is owned by the survivor.
- R11: One cycle after `alive` falls, every resource held by the dead processor is held by the survivor. Claims by a dead processor are ignored.
- R12: While both processors are dead, every request is answered busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_rand | input | 1 | 0: alternate, 1: pseudo-random assignment |
| hb_timeout | input | TW | Heartbeat silence limit in cycles, 0 disables |
| hb | input | 2 | Heartbeat of processor 1 and 0 |
| alive | output | 2 | Health state of processor 1 and 0 |
| req_valid | input | 1 | New call request |
| req_id | input | ID_W | Identifier of the new call |
| done_valid | input | 1 | Call completion |
| done_id | input | ID_W | Identifier of the completed call |
| asg_valid | output | 1 | Answer to last cycle's request |
| asg_proc | output | 1 | Processor chosen |
| asg_busy | output | 1 | Request rejected |
| qry_id | input | ID_W | Identifier to look up |
| qry_hit | output | 1 | Identifier is live |
| qry_owner | output | 1 | Current owner of the identifier |
| lk_set0 | input | N_RES | Claims by processor 0 |
| lk_clr0 | input | N_RES | Releases by processor 0 |
| lk_set1 | input | N_RES | Claims by processor 1 |
| lk_clr1 | input | N_RES | Releases by processor 1 |
| lk_own0 | output | N_RES | Resources held by processor 0 |
| lk_own1 | output | N_RES | Resources held by processor 1 |
| lk_err | output | 2 | Foreign-release error pulse per processor |

## Verification
Two pairs of functions can land in the same cycle:
- A completion that arrives with a request while the table is full. The bench fills the table with directed requests, then presents the extra request together with a completion. It expects a busy answer, followed by acceptance on a retry.
- A release by the holder together with a claim by the other processor on the same resource. The bench expects the resource to be free afterwards rather than handed over.

Failover is timed exactly: the bench expects the health bit to fall after the programmed silence and no earlier. Ownership and flag transfer are then checked through the lookup port and the grant outputs.

// File: rtl/callshare_pkg.sv
package callshare_pkg;

    typedef enum logic {
        HB_WATCH  = 1'b0,
        HB_FAILED = 1'b1
    } hb_state_e;

    typedef enum logic [1:0] {
        LK_FREE  = 2'd0,
        LK_HELD0 = 2'd1,
        LK_HELD1 = 2'd2
    } lk_state_e;

    localparam logic [15:0] LFSR_SEED = 16'hACE1;

    function automatic logic [15:0] lfsr_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/callshare_health.sv
module callshare_health
    import callshare_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hb,
    input  logic [TW-1:0] tmo,
    output logic          alive
);
    hb_state_e     st, st_nxt;
    logic [TW-1:0] quiet;
    logic [TW:0]   quiet_inc;

    assign quiet_inc = {1'b0, quiet} + 1'b1;

    // cycles since last heartbeat, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                quiet <= '0;
        else if (hb)               quiet <= '0;
        else if (quiet != '1)      quiet <= quiet + 1'b1;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            HB_WATCH:  if (!hb && tmo != '0 && quiet_inc >= {1'b0, tmo}) st_nxt = HB_FAILED;
            HB_FAILED: st_nxt = HB_FAILED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= HB_WATCH;
        else        st <= st_nxt;
    end

    always_comb alive = (st == HB_WATCH);

endmodule

// File: rtl/callshare_lock.sv
module callshare_lock
    import callshare_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] alive,
    input  logic       set0,
    input  logic       clr0,
    input  logic       set1,
    input  logic       clr1,
    output logic       own0,
    output logic       own1,
    output logic       bad0,
    output logic       bad1
);
    lk_state_e st, st_nxt;

    always_comb begin
        st_nxt = st;
        unique case (st)
            LK_FREE: begin
                if (set0 && alive[0])      st_nxt = LK_HELD0;
                else if (set1 && alive[1]) st_nxt = LK_HELD1;
            end
            LK_HELD0: begin
                if (!alive[0] && alive[1]) st_nxt = LK_HELD1;
                else if (clr0)             st_nxt = LK_FREE;
            end
            LK_HELD1: begin
                if (!alive[1] && alive[0]) st_nxt = LK_HELD0;
                else if (clr1)             st_nxt = LK_FREE;
            end
            default: st_nxt = LK_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= LK_FREE;
        else        st <= st_nxt;
    end

    always_comb begin
        own0 = (st == LK_HELD0);
        own1 = (st == LK_HELD1);
        bad0 = clr0 && (st != LK_HELD0);
        bad1 = clr1 && (st != LK_HELD1);
    end

endmodule

// File: rtl/callshare_table.sv
module callshare_table
    import callshare_pkg::*;
#(
    parameter int N_CALLS = 8,
    parameter int ID_W    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_rand,
    input  logic [1:0]      alive,
    input  logic            req_valid,
    input  logic [ID_W-1:0] req_id,
    input  logic            done_valid,
    input  logic [ID_W-1:0] done_id,
    input  logic [ID_W-1:0] qry_id,
    output logic            asg_valid,
    output logic            asg_proc,
    output logic            asg_busy,
    output logic            qry_hit,
    output logic            qry_owner
);
    localparam int IW = (N_CALLS > 1) ? $clog2(N_CALLS) : 1;

    logic [N_CALLS-1:0] vld;
    logic [N_CALLS-1:0] own;
    logic [ID_W-1:0]    ids [N_CALLS];
    logic               rr;
    logic [15:0]        lfsr;

    logic [IW-1:0]      free_idx;
    logic               have_free;
    logic               pick;
    logic               accept;

    always_comb begin
        free_idx  = '0;
        have_free = 1'b0;
        for (int i = N_CALLS - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_idx  = IW'(i);
                have_free = 1'b1;
            end
        end
    end

    always_comb begin
        unique case (alive)
            2'b11:   pick = mode_rand ? lfsr[0] : rr;
            2'b10:   pick = 1'b1;
            default: pick = 1'b0;
        endcase
        accept = req_valid && have_free && (alive != 2'b00);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            own <= '0;
            for (int i = 0; i < N_CALLS; i++) ids[i] <= '0;
        end else begin
            for (int i = 0; i < N_CALLS; i++) begin
                if (done_valid && vld[i] && ids[i] == done_id)
                    vld[i] <= 1'b0;
                if (vld[i] && !alive[own[i]] && alive[~own[i]])
                    own[i] <= ~own[i];
                if (accept && free_idx == IW'(i)) begin
                    vld[i] <= 1'b1;
                    ids[i] <= req_id;
                    own[i] <= pick;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr   <= 1'b0;
            lfsr <= LFSR_SEED;
        end else if (accept && alive == 2'b11) begin
            if (mode_rand) lfsr <= lfsr_step(lfsr);
            else           rr   <= ~rr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asg_valid <= 1'b0;
            asg_busy  <= 1'b0;
            asg_proc  <= 1'b0;
        end else begin
            asg_valid <= req_valid;
            asg_busy  <= req_valid && !accept;
            asg_proc  <= accept ? pick : 1'b0;
        end
    end

    always_comb begin
        qry_hit   = 1'b0;
        qry_owner = 1'b0;
        for (int i = 0; i < N_CALLS; i++) begin
            if (vld[i] && ids[i] == qry_id) begin
                qry_hit   = 1'b1;
                qry_owner = own[i];
            end
        end
    end

endmodule

// File: rtl/callshare_top.sv
module callshare_top
    import callshare_pkg::*;
#(
    parameter int N_CALLS = 8,
    parameter int ID_W    = 8,
    parameter int N_RES   = 4,
    parameter int TW      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_rand,
    input  logic [TW-1:0]    hb_timeout,
    input  logic [1:0]       hb,
    output logic [1:0]       alive,
    input  logic             req_valid,
    input  logic [ID_W-1:0]  req_id,
    input  logic             done_valid,
    input  logic [ID_W-1:0]  done_id,
    output logic             asg_valid,
    output logic             asg_proc,
    output logic             asg_busy,
    input  logic [ID_W-1:0]  qry_id,
    output logic             qry_hit,
    output logic             qry_owner,
    input  logic [N_RES-1:0] lk_set0,
    input  logic [N_RES-1:0] lk_clr0,
    input  logic [N_RES-1:0] lk_set1,
    input  logic [N_RES-1:0] lk_clr1,
    output logic [N_RES-1:0] lk_own0,
    output logic [N_RES-1:0] lk_own1,
    output logic [1:0]       lk_err
);
    logic [N_RES-1:0] bad0, bad1;

    for (genvar p = 0; p < 2; p++) begin : g_proc
        callshare_health #(.TW(TW)) u_health (
            .clk   (clk),
            .rst_n (rst_n),
            .hb    (hb[p]),
            .tmo   (hb_timeout),
            .alive (alive[p])
        );
    end

    for (genvar r = 0; r < N_RES; r++) begin : g_res
        callshare_lock u_lock (
            .clk   (clk),
            .rst_n (rst_n),
            .alive (alive),
            .set0  (lk_set0[r]),
            .clr0  (lk_clr0[r]),
            .set1  (lk_set1[r]),
            .clr1  (lk_clr1[r]),
            .own0  (lk_own0[r]),
            .own1  (lk_own1[r]),
            .bad0  (bad0[r]),
            .bad1  (bad1[r])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lk_err <= 2'b00;
        else        lk_err <= {|bad1, |bad0};
    end

    callshare_table #(.N_CALLS(N_CALLS), .ID_W(ID_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_rand  (mode_rand),
        .alive      (alive),
        .req_valid  (req_valid),
        .req_id     (req_id),
        .done_valid (done_valid),
        .done_id    (done_id),
        .qry_id     (qry_id),
        .asg_valid  (asg_valid),
        .asg_proc   (asg_proc),
        .asg_busy   (asg_busy),
        .qry_hit    (qry_hit),
        .qry_owner  (qry_owner)
    );

endmodule

// File: rtl/callshare_chk.sv
module callshare_chk #(
    parameter int N_RES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             asg_valid,
    input logic             asg_busy,
    input logic             asg_proc,
    input logic [1:0]       alive,
    input logic [N_RES-1:0] lk_clr0,
    input logic [N_RES-1:0] lk_clr1,
    input logic [N_RES-1:0] lk_own0,
    input logic [N_RES-1:0] lk_own1,
    input logic [1:0]       lk_err
);
    assert_answer_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        asg_valid |-> $past(req_valid));

    assert_release_only_by_holder0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(alive[0]) |-> (($past(lk_own0) & ~lk_own0 & ~$past(lk_clr0)) == '0));

    assert_release_only_by_holder1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(alive[1]) |-> (($past(lk_own1) & ~lk_own1 & ~$past(lk_clr1)) == '0));

    assert_err0_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_err[0] |-> ($past(lk_clr0) != '0));

    assert_err1_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_err[1] |-> ($past(lk_clr1) != '0));

    assert_dead0_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !alive[0] |=> !alive[0]);

    assert_dead1_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !alive[1] |=> !alive[1]);

    assert_solo0_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (asg_valid && !asg_busy && $past(alive) == 2'b01) |-> !asg_proc);

    assert_solo1_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (asg_valid && !asg_busy && $past(alive) == 2'b10) |-> asg_proc);

    assert_halt_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (asg_valid && $past(alive) == 2'b00) |-> asg_busy);

endmodule

bind callshare_top callshare_chk #(.N_RES(N_RES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .asg_valid (asg_valid),
    .asg_busy  (asg_busy),
    .asg_proc  (asg_proc),
    .alive     (alive),
    .lk_clr0   (lk_clr0),
    .lk_clr1   (lk_clr1),
    .lk_own0   (lk_own0),
    .lk_own1   (lk_own1),
    .lk_err    (lk_err)
);

// File: tb/tb_callshare_top.sv
module tb_callshare_top;
    localparam int NC = 8;
    localparam int NR = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_rand;
    logic [7:0] hb_timeout;
    logic [1:0] hb;
    logic [1:0] alive;
    logic       req_valid, done_valid;
    logic [7:0] req_id, done_id, qry_id;
    logic       asg_valid, asg_proc, asg_busy, qry_hit, qry_owner;
    logic [NR-1:0] lk_set0, lk_clr0, lk_set1, lk_clr1, lk_own0, lk_own1;
    logic [1:0] lk_err;

    int n_chk = 0;
    int n_err = 0;

    bit        m_act [256];
    bit        m_own [256];
    int        m_cnt = 0;
    bit        m_rr  = 1'b0;
    bit [15:0] m_lf  = 16'hACE1;
    bit [1:0]  m_alive = 2'b11;

    callshare_top #(.N_CALLS(NC), .ID_W(8), .N_RES(NR), .TW(8)) dut (.*);

    always #4 clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit [15:0] lf_next(input bit [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic bit exp_choice();
        if (m_alive == 2'b01) return 1'b0;
        if (m_alive == 2'b10) return 1'b1;
        return mode_rand ? m_lf[0] : m_rr;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic call_cycle(input bit rq, input int rid, input bit dn, input int did,
                              input string tag);
        bit acc, ch;
        acc = rq && (m_cnt < NC) && (m_alive != 2'b00);
        ch  = exp_choice();
        req_valid  = rq;  req_id  = rid[7:0];
        done_valid = dn;  done_id = did[7:0];
        tick();
        req_valid = 1'b0; done_valid = 1'b0;
        chk(tag, "asg_valid", asg_valid, rq);
        if (rq) begin
            chk(tag, "asg_busy", asg_busy, !acc);
            if (acc) chk(tag, "asg_proc", asg_proc, ch);
        end
        if (dn && m_act[did]) begin m_act[did] = 1'b0; m_cnt--; end
        if (acc) begin
            m_act[rid] = 1'b1; m_own[rid] = ch; m_cnt++;
            if (m_alive == 2'b11) begin
                if (mode_rand) m_lf = lf_next(m_lf);
                else           m_rr = ~m_rr;
            end
        end
    endtask

    task automatic query(input int id, input string tag);
        qry_id = id[7:0];
        #1;
        chk(tag, "qry_hit", qry_hit, m_act[id]);
        if (m_act[id]) chk(tag, "qry_owner", qry_owner, m_own[id]);
    endtask

    task automatic lock_cycle(input bit [NR-1:0] s0, input bit [NR-1:0] c0,
                              input bit [NR-1:0] s1, input bit [NR-1:0] c1);
        lk_set0 = s0; lk_clr0 = c0; lk_set1 = s1; lk_clr1 = c1;
        tick();
        lk_set0 = '0; lk_clr0 = '0; lk_set1 = '0; lk_clr1 = '0;
    endtask

    task automatic drain(input string tag);
        for (int id = 0; id < 256; id++)
            if (m_act[id]) call_cycle(1'b0, 0, 1'b1, id, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not finish act=0 exp=1");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd5417));
        rst_n = 1'b0; mode_rand = 1'b0; hb_timeout = 8'd16; hb = 2'b11;
        req_valid = 1'b0; done_valid = 1'b0; req_id = '0; done_id = '0; qry_id = '0;
        lk_set0 = '0; lk_clr0 = '0; lk_set1 = '0; lk_clr1 = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "alive", alive, 2'b11);
        chk("R1", "lk_own0", lk_own0, 0);
        chk("R1", "lk_own1", lk_own1, 0);
        chk("R1", "asg_valid", asg_valid, 0);
        chk("R1", "lk_err", lk_err, 0);
        query(1, "R1");

        // R2 alternation
        for (int i = 1; i <= 4; i++) call_cycle(1'b1, i, 1'b0, 0, "R2");
        for (int i = 1; i <= 4; i++) query(i, "R4");
        drain("R4");
        for (int i = 1; i <= 4; i++) query(i, "R4");

        // R5 full table, and completion in the same cycle as a request
        for (int i = 10; i < 10 + NC; i++) call_cycle(1'b1, i, 1'b0, 0, "R5");
        call_cycle(1'b1, 40, 1'b0, 0, "R5");
        call_cycle(1'b1, 41, 1'b1, 10, "R5");
        call_cycle(1'b1, 41, 1'b0, 0, "R5");
        query(41, "R5");
        query(10, "R4");
        drain("R5");

        // random traffic in both assignment modes
        for (int phase = 0; phase < 2; phase++) begin
            mode_rand = phase[0];
            for (int n = 0; n < 200; n++) begin
                bit rq, dn;
                int rid, did;
                rq = ($urandom % 2) == 0;
                dn = 1'b0; did = 0;
                if (m_cnt > 0 && ($urandom % 3) == 0) begin
                    int st;
                    st = $urandom % 256;
                    for (int k = 0; k < 256; k++) begin
                        if (!dn && m_act[(st + k) % 256]) begin dn = 1'b1; did = (st + k) % 256; end
                    end
                end
                do rid = $urandom % 256; while (m_act[rid] || (dn && rid == did));
                call_cycle(rq, rid, dn, did, phase ? "R3" : "R2");
                if (rq) query(rid, "R4");
            end
            drain("R4");
        end
        mode_rand = 1'b0;

        // resource exclusion
        lock_cycle(4'b0001, 0, 0, 0);
        chk("R6", "own0 after claim", lk_own0, 4'b0001);
        lock_cycle(0, 0, 4'b0001, 0);
        chk("R6", "own1 blocked", lk_own1, 0);
        chk("R6", "own0 kept", lk_own0, 4'b0001);
        lock_cycle(0, 0, 0, 4'b0001);
        chk("R8", "err after foreign release", lk_err, 2'b10);
        chk("R8", "own0 unchanged", lk_own0, 4'b0001);
        tick();
        chk("R8", "err one cycle", lk_err, 2'b00);
        lock_cycle(4'b0010, 0, 4'b0010, 0);
        chk("R7", "tie own0", lk_own0, 4'b0011);
        chk("R7", "tie own1", lk_own1, 0);
        lock_cycle(0, 4'b0001, 4'b0001, 0);
        chk("R6", "release+claim own0", lk_own0, 4'b0010);
        chk("R6", "release+claim own1", lk_own1, 0);
        chk("R6", "release+claim err", lk_err, 0);
        lock_cycle(0, 0, 4'b0101, 0);
        chk("R6", "own1 after claims", lk_own1, 4'b0101);
        lock_cycle(0, 4'b1000, 0, 0);
        chk("R8", "err release of free", lk_err, 2'b01);
        chk("R8", "free stays free", lk_own0 | lk_own1, 4'b0111);
        lock_cycle(0, 4'b0010, 0, 0);
        chk("R6", "holder release", lk_own0, 0);

        // calls split across processors, then processor 1 falls silent
        for (int i = 60; i < 64; i++) call_cycle(1'b1, i, 1'b0, 0, "R2");
        hb = 2'b01;
        for (int i = 0; i < 15; i++) tick();
        chk("R9", "alive before limit", alive, 2'b11);
        tick();
        chk("R9", "alive at limit", alive, 2'b01);
        m_alive = 2'b01;
        tick();
        for (int i = 60; i < 64; i++) m_own[i] = 1'b0;
        for (int i = 60; i < 64; i++) query(i, "R10");
        chk("R11", "locks moved own0", lk_own0, 4'b0101);
        chk("R11", "locks moved own1", lk_own1, 0);
        for (int i = 70; i < 73; i++) call_cycle(1'b1, i, 1'b0, 0, "R10");
        lock_cycle(0, 0, 4'b1000, 0);
        chk("R11", "dead claim ignored", lk_own1, 0);
        hb = 2'b11;
        repeat (3) tick();
        chk("R9", "death sticky", alive, 2'b01);

        // detection disabled, then re-enabled with processor 0 silent
        hb_timeout = 8'd0;
        hb = 2'b00;
        repeat (40) tick();
        chk("R9", "zero limit disables", alive, 2'b01);
        hb_timeout = 8'd16;
        tick();
        chk("R9", "limit re-armed", alive, 2'b00);
        m_alive = 2'b00;
        call_cycle(1'b1, 90, 1'b0, 0, "R12");
        call_cycle(1'b1, 91, 1'b1, 60, "R12");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule